// File: doc/BRIEF.md
# Short-Circuit Event Window Detector

This block watches a switching converter's oscillator cycle by cycle and decides when the converter has a short circuit. A short circuit is current limit firing while the duty cycle is already cut back. In each cycle the block checks one thing: did a current-limit event arrive while the digital ramp was still at or below a programmable threshold? If it did, and the ramp had not yet passed that threshold earlier in the cycle, the cycle is marked as a short-circuit cycle. The threshold code sets the threshold as a fraction of maximum duty. The code is read as a setting whose half value is the duty fraction, so the mid-scale code stands for 50% of maximum duty.

The block keeps the verdicts of the last 32 closed cycles in a sliding record with a running event count. It raises a one-clock shutdown request when a newly recorded event leaves at least 8 events in that record. Detection runs only after soft-start has finished and only while the threshold code is non-zero. When either condition is missing, no cycle is judged and the record is emptied.

All pins are plain control and status signals. There is no streaming data path, so there is no valid/ready handshake and no back-pressure. The cycle-start strobe marks the first clock of each oscillator cycle, and it also closes the cycle before it.

Top module: `sc_window_detector`

## Requirements
- R1: A cycle counts as an event when `ilim` is high on a clock where `ramp` is less than or equal to the threshold level, and `ramp` has not been above that level on any earlier clock of the same cycle. A cycle runs from one `cyc_start` clock up to the clock before the next one.
- R2: When a cycle closes, its verdict is recorded. If the verdict is an event and the record then holds at least 8 events, `sc_req` is high for exactly one clock, in the clock after the closing `cyc_start`. `sc_req` is low at all other times, including after reset.
- R3: The threshold level on the `RW`-bit ramp scale is `thr_code` × 2^(`RW`−`TW`). With the defaults, code 128 gives level 512 (50% of a 1024-step ramp) and code 64 gives level 256.
- R4: A cycle contributes at most one event, however many clocks of `ilim` it contains.
- R5: When `thr_code` is 0, detection is off: no event is recorded, `sc_req` stays low and the record is cleared. Events recorded before the code went to 0 do not count afterwards.
- R6: When `ss_done` is low, detection is off in the same way as in R5, and the record is cleared.
- R7: The record covers only the 32 most recently closed cycles. An event that is 33 or more closed cycles old no longer counts toward the 8.
- R8: An `ilim` on the clock where `ramp` first goes above the threshold level, or on any later clock of that cycle, is not an event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cyc_start | input | 1 | High for one clock at the start of each oscillator cycle |
| ramp | input | RW | Ramp value of the current cycle, full scale = maximum duty |
| ilim | input | 1 | Current-limit event for this clock |
| thr_code | input | TW | Threshold setting; 0 turns detection off |
| ss_done | input | 1 | High once soft-start has completed |
| sc_req | output | 1 | One-clock shutdown request |

## Verification
A cycle's verdict is registered at the closing `cyc_start` edge, and `sc_req` is registered at that same edge. So the request for cycle N shows up one clock after the strobe that starts cycle N+1. The bench drives on falling edges and reads `sc_req` on the falling edge that follows the strobe clock. It compares that value with the request expected for the cycle just closed, and it requires `sc_req` to be low at every other falling edge. The effect of turning detection off is checked at the ports: after detection comes back on, a fresh event must not raise a request that the earlier events would have completed.

// File: rtl/scwin_pkg.sv
package scwin_pkg;
  // Verdict of one closed oscillator cycle
  typedef struct packed {
    logic valid;  // a cycle closed on this clock
    logic hit;    // that cycle held a short-circuit event
  } verdict_t;
endpackage

// File: rtl/scwin_thresh.sv
module scwin_thresh #(
  parameter int RW = 10,
  parameter int TW = 8
) (
  input  logic [TW-1:0] thr_code,
  output logic [RW-1:0] thr_lvl,
  output logic          thr_on
);
  // Code full scale spans the whole ramp: level = code * 2^(RW-TW)
  generate
    if (RW > TW) begin : g_widen
      assign thr_lvl = {thr_code, {(RW-TW){1'b0}}};
    end else if (RW == TW) begin : g_same
      assign thr_lvl = thr_code;
    end else begin : g_narrow
      assign thr_lvl = thr_code[TW-1 -: RW];
    end
  endgenerate

  assign thr_on = |thr_code;
endmodule

// File: rtl/scwin_qual.sv
module scwin_qual #(
  parameter int RW = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic               cyc_start,
  input  logic [RW-1:0]      ramp,
  input  logic [RW-1:0]      thr_lvl,
  input  logic               ilim,
  output scwin_pkg::verdict_t verdict
);
  logic crossed_q;   // ramp has passed the level earlier in this cycle
  logic seen_q;      // an event already happened in this cycle
  logic over_now;
  logic crossed_eff;
  logic hit_now;

  assign over_now    = ramp > thr_lvl;
  assign crossed_eff = cyc_start ? 1'b0 : crossed_q;
  assign hit_now     = ilim & ~over_now & ~crossed_eff;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crossed_q <= 1'b0;
      seen_q    <= 1'b0;
    end else if (clr) begin
      crossed_q <= 1'b0;
      seen_q    <= 1'b0;
    end else if (cyc_start) begin
      crossed_q <= over_now;
      seen_q    <= hit_now;
    end else begin
      crossed_q <= crossed_q | over_now;
      seen_q    <= seen_q | hit_now;
    end
  end

  // The strobe closes the previous cycle with its sticky event flag
  always_comb begin
    verdict.valid = cyc_start & ~clr;
    verdict.hit   = seen_q;
  end
endmodule

// File: rtl/scwin_window.sv
module scwin_window #(
  parameter int WIN  = 32,
  parameter int TRIP = 8,
  parameter int CW   = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clr,
  input  scwin_pkg::verdict_t vin,
  output logic                trip,
  output logic [CW-1:0]       cnt,
  output logic [WIN-1:0]      bits
);
  logic [CW-1:0] cnt_nx;
  logic          oldest;

  assign oldest = bits[WIN-1];

  always_comb cnt_nx = cnt + CW'(vin.hit) - CW'(oldest);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bits <= '0;
      cnt  <= '0;
      trip <= 1'b0;
    end else if (clr) begin
      bits <= '0;
      cnt  <= '0;
      trip <= 1'b0;
    end else if (vin.valid) begin
      bits <= {bits[WIN-2:0], vin.hit};
      cnt  <= cnt_nx;
      trip <= vin.hit && (cnt_nx >= CW'(TRIP));
    end else begin
      trip <= 1'b0;
    end
  end
endmodule

// File: rtl/sc_window_detector.sv
module sc_window_detector #(
  parameter int RW   = 10,
  parameter int TW   = 8,
  parameter int WIN  = 32,
  parameter int TRIP = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cyc_start,
  input  logic [RW-1:0] ramp,
  input  logic          ilim,
  input  logic [TW-1:0] thr_code,
  input  logic          ss_done,
  output logic          sc_req
);
  localparam int CW = $clog2(WIN + 1);

  logic [RW-1:0]       thr_lvl;
  logic                thr_on;
  logic                det_clr;
  scwin_pkg::verdict_t verdict;
  logic [CW-1:0]       win_cnt;
  logic [WIN-1:0]      win_bits;

  scwin_thresh #(.RW(RW), .TW(TW)) u_thresh (
    .thr_code (thr_code),
    .thr_lvl  (thr_lvl),
    .thr_on   (thr_on)
  );

  // Detection runs only after soft-start with a non-zero setting
  assign det_clr = ~(thr_on & ss_done);

  scwin_qual #(.RW(RW)) u_qual (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (det_clr),
    .cyc_start (cyc_start),
    .ramp      (ramp),
    .thr_lvl   (thr_lvl),
    .ilim      (ilim),
    .verdict   (verdict)
  );

  scwin_window #(.WIN(WIN), .TRIP(TRIP), .CW(CW)) u_window (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (det_clr),
    .vin   (verdict),
    .trip  (sc_req),
    .cnt   (win_cnt),
    .bits  (win_bits)
  );
endmodule

// File: rtl/scwin_checker.sv
module scwin_checker #(
  parameter int TW   = 8,
  parameter int WIN  = 32,
  parameter int TRIP = 8,
  parameter int CW   = 6
) (
  input logic           clk,
  input logic           rst_n,
  input logic           cyc_start,
  input logic [TW-1:0]  thr_code,
  input logic           ss_done,
  input logic           sc_req,
  input logic [CW-1:0]  win_cnt,
  input logic [WIN-1:0] win_bits
);
  AST_REQ_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    sc_req |-> $past(cyc_start));  // R2

  AST_REQ_AT_TRIP: assert property (@(posedge clk) disable iff (!rst_n)
    sc_req |-> (win_cnt >= CW'(TRIP)));  // R2

  AST_ZERO_CODE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (thr_code == '0) |=> (!sc_req && win_cnt == '0));  // R5

  AST_SS_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    !ss_done |=> (!sc_req && win_cnt == '0));  // R6

  AST_COUNT_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    win_cnt == CW'($countones(win_bits)));  // R7

  AST_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (ss_done && thr_code != '0) |=>
      (win_cnt == $past(win_cnt) || win_cnt == $past(win_cnt) + CW'(1)
       || win_cnt + CW'(1) == $past(win_cnt)));  // R4
endmodule

bind sc_window_detector scwin_checker #(
  .TW(TW), .WIN(WIN), .TRIP(TRIP), .CW(CW)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cyc_start (cyc_start),
  .thr_code  (thr_code),
  .ss_done   (ss_done),
  .sc_req    (sc_req),
  .win_cnt   (win_cnt),
  .win_bits  (win_bits)
);

// File: tb/sc_window_detector_test.sv
module sc_window_detector_test;
  localparam int CLK_P = 10;
  localparam int RW    = 10;
  localparam int TW    = 8;
  localparam int L     = 8;   // clocks per oscillator cycle; ramp = k*128

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cyc_start = 1'b0;
  logic [RW-1:0] ramp = '0;
  logic          ilim = 1'b0;
  logic [TW-1:0] thr_code = '0;
  logic          ss_done = 1'b0;
  logic          sc_req;

  int   errors = 0;
  int   checks = 0;
  logic close_req = 1'b0;
  logic stray = 1'b0;
  logic done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  sc_window_detector uut (
    .clk(clk), .rst_n(rst_n), .cyc_start(cyc_start), .ramp(ramp),
    .ilim(ilim), .thr_code(thr_code), .ss_done(ss_done), .sc_req(sc_req)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // One oscillator cycle. ilim is high on clocks j0..j0+np-1.
  // close_req = request for the cycle closed by this cycle's strobe.
  task automatic run_cycle(input int j0, input int np);
    for (int k = 0; k < L; k++) begin
      @(negedge clk);
      if (k == 1) close_req = sc_req;
      else if (sc_req) stray = 1'b1;
      cyc_start = (k == 0);
      ramp      = RW'(k * 128);
      ilim      = (np > 0) && (k >= j0) && (k < j0 + np);
    end
  endtask

  task automatic run_many(input int n, input int j0, input int np);
    for (int i = 0; i < n; i++) run_cycle(j0, np);
  endtask

  task automatic clear_hist();
    @(negedge clk);
    cyc_start = 1'b0; ilim = 1'b0; ss_done = 1'b0;
    @(negedge clk);
    @(negedge clk);
    ss_done = 1'b1;
    stray = 1'b0;
  endtask

  task automatic t_reset();
    check("R2 reset output", int'(sc_req), 0);
  endtask

  task automatic t_basic();
    clear_hist(); thr_code = 8'd128;
    run_many(7, 4, 1);
    run_cycle(4, 1);
    check("R2 seven events no request", int'(close_req), 0);
    run_cycle(-1, 0);
    check("R1 eighth event at ramp==level requests", int'(close_req), 1);
    run_cycle(4, 1);
    check("R2 single pulse", int'(close_req) + int'(stray), 0);
    run_cycle(-1, 0);
    check("R2 ninth event requests again", int'(close_req), 1);
  endtask

  task automatic t_late();
    clear_hist(); thr_code = 8'd128;
    run_many(8, 5, 3);
    run_cycle(-1, 0);
    check("R8 ilim at or after crossing ignored", int'(close_req) + int'(stray), 0);
  endtask

  task automatic t_multi();
    clear_hist(); thr_code = 8'd128;
    run_many(7, 0, 4);
    run_cycle(0, 4);
    check("R4 many pulses count once", int'(close_req) + int'(stray), 0);
    run_cycle(-1, 0);
    check("R4 eighth multi-pulse cycle requests", int'(close_req), 1);
  endtask

  task automatic t_slide();
    clear_hist(); thr_code = 8'd128;
    run_many(7, 4, 1); run_many(25, -1, 0); run_cycle(4, 1); run_cycle(-1, 0);
    check("R7 event aged out of window", int'(close_req) + int'(stray), 0);
    clear_hist();
    run_many(7, 4, 1); run_many(24, -1, 0); run_cycle(4, 1); run_cycle(-1, 0);
    check("R7 eight events within 32 cycles", int'(close_req), 1);
  endtask

  task automatic t_code0();
    clear_hist(); thr_code = 8'd0;
    run_many(10, 0, 1); run_cycle(-1, 0);
    check("R5 zero code never requests", int'(close_req) + int'(stray), 0);
    thr_code = 8'd128;
    run_many(7, 4, 1);
    thr_code = 8'd0; run_cycle(4, 1);
    thr_code = 8'd128; run_cycle(4, 1); run_cycle(-1, 0);
    check("R5 zero code clears history", int'(close_req) + int'(stray), 0);
  endtask

  task automatic t_ss();
    clear_hist(); thr_code = 8'd128;
    run_many(7, 4, 1);
    ss_done = 1'b0; run_cycle(4, 1);
    ss_done = 1'b1; run_cycle(4, 1); run_cycle(-1, 0);
    check("R6 soft-start clears history", int'(close_req) + int'(stray), 0);
    ss_done = 1'b0; run_many(9, 0, 1); run_cycle(-1, 0);
    check("R6 no request during soft-start", int'(close_req) + int'(stray), 0);
    ss_done = 1'b1;
  endtask

  task automatic t_code64();
    clear_hist(); thr_code = 8'd64;
    run_many(8, 3, 1); run_cycle(-1, 0);
    check("R3 code 64 ramp 384 above level", int'(close_req) + int'(stray), 0);
    clear_hist();
    run_many(8, 2, 1); run_cycle(-1, 0);
    check("R3 code 64 ramp 256 at level", int'(close_req), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_basic();
    t_late();
    t_multi();
    t_slide();
    t_code0();
    t_ss();
    t_code64();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule